// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block converts one configuration-space access into a configuration request packet with a three-dword header. The access names a target bus, a device/function number, a register offset, a size of 1, 2 or 4 bytes, a direction and write data. The packet leaves the block as a series of 64-bit beats on a valid/ready transmit port. Each beat carries a start flag and an end flag. Within a beat, slot 0 is bits [31:0] and slot 1 is bits [63:32].

The block keeps its own copy of the root bus number. It compares the target bus with this copy to choose between the local-bus form (Type 0) and the forwarded form (Type 1). It builds the byte enables and moves the write data into the correct byte lane. The data goes into a different beat depending on whether the offset is quadword aligned.

After the last beat is sent, the block waits for a completion result from outside. Only then does it return to idle. If a write to the primary-bus register on the root bus completes successfully, the block loads a new root bus number from that write.

Top module: `cfg_tlp_builder`

## Requirements
- R1: Header dword 0 is {fmt_type[7:0], 24'h000001}. fmt_type is 0x04 for a read and 0x44 for a write when the target bus equals the stored root bus number. For any other bus it is 0x05 for a read and 0x45 for a write.
- R2: Header dword 1 is {root bus[7:0], ROOT_DEVFN[7:0], tag[7:0], 4'h0, byte_enable[3:0]}. The tag is 0x1D for reads and 0x10 for writes.
- R3: Header dword 2 is {bus[7:0], devfn[7:0], 4'h0, offset[11:2], 2'b00}.
- R4: The size encoding is 0 for byte, 1 for halfword, and 2 or 3 for dword. The byte enables are 4'b0001<<offset[1:0] for a byte access and 4'b0011<<offset[1:0] for a halfword access, each truncated to 4 bits. They are 4'hF for a dword access.
- R5: Write data is placed as wdata<<(8*offset[1:0]), truncated to 32 bits. A read carries a zero data slot.
- R6: The first beat is {dword 1, dword 0}, with the start flag set and the end flag clear. No beat has both flags set.
- R7: A write with offset[2:0]==0 takes three beats. Beat 2 is {32'h0, dword 2} with no end flag. Beat 3 is {32'h0, data} with the end flag set.
- R8: Any other write, and every read, takes two beats. Beat 2 is {data, dword 2} with the end flag set.
- R9: While tx_valid_o is high and tx_ready_i is low, the beat on the port holds its value.
- R10: A request is accepted only when req_ready_o is high, which is only while idle. Requests presented while busy are ignored. busy_o stays high from acceptance until a completion strobe arrives after the last beat.
- R11: After reset, the root bus number is RESET_ROOT_BUS (0). It takes the low byte of the placed write data when a write completes with cpl_ok_i=1, targets the root bus, and has dword-aligned offset 0x18.
- R12: A failed completion, a read, or a write to offset 0x18 on a non-root bus leaves the root bus number unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Target bus number |
| req_devfn_i | input | 8 | Target device/function |
| req_offset_i | input | 12 | Register byte offset |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 dword |
| req_wdata_i | input | 32 | Write value, right aligned |
| tx_valid_o | output | 1 | Beat valid |
| tx_ready_i | input | 1 | Beat accepted |
| tx_data_o | output | 64 | Beat payload, slot 0 in [31:0] |
| tx_sop_o | output | 1 | First beat of packet |
| tx_eop_o | output | 1 | Last beat of packet |
| cpl_valid_i | input | 1 | Completion result strobe |
| cpl_ok_i | input | 1 | Completion succeeded |
| busy_o | output | 1 | Request in progress |
| root_bus_o | output | 8 | Stored root bus number |

## Verification
The root bus number only changes after a narrow sequence: a successful write to one register on the current root bus. Its effect appears only in the headers of later packets. The stimulus first moves the root bus number with such a write. It then sends reads to both the old and the new bus and checks that the Type 0 and Type 1 choice swaps. Three near misses (a failed completion, a read, and a foreign bus) are each followed by a packet whose header would show a wrong update. Stalls on tx_ready_i are interleaved with requests presented while busy, to show that beats hold and that no extra beat appears.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;
  localparam int unsigned DW = 32;
  localparam logic [7:0] FT_RD0 = 8'h04;
  localparam logic [7:0] FT_WR_BIT = 8'h40;
  localparam logic [7:0] FT_TYPE1_BIT = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BEAT1,
    ST_BEAT2,
    ST_BEAT3,
    ST_WAIT
  } seq_state_e;
endpackage

// File: rtl/cfg_hdr_gen.sv
module cfg_hdr_gen
  import cfg_tlp_pkg::*;
#(
  parameter int unsigned OFS_W = 12,
  parameter logic [7:0] ROOT_DEVFN = 8'h00,
  parameter logic [7:0] RD_TAG = 8'h1D,
  parameter logic [7:0] WR_TAG = 8'h10,
  parameter logic [OFS_W-1:0] PRIM_OFS = 'h18
) (
  input  logic             write_i,
  input  logic [7:0]       bus_i,
  input  logic [7:0]       devfn_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [1:0]       size_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [7:0]       root_bus_i,
  output logic [DW-1:0]    dw0_o,
  output logic [DW-1:0]    dw1_o,
  output logic [DW-1:0]    dw2_o,
  output logic [DW-1:0]    data_o,
  output logic             three_beat_o,
  output logic             prim_hit_o
);
  localparam int unsigned PAD_W = 16 - OFS_W;

  logic       local_bus;
  logic [7:0] fmt_type;
  logic [3:0] be;
  logic [OFS_W-1:0] ofs_dw;

  assign local_bus = (bus_i == root_bus_i);
  assign fmt_type  = FT_RD0 | (write_i ? FT_WR_BIT : 8'h00)
                   | (local_bus ? 8'h00 : FT_TYPE1_BIT);
  assign ofs_dw    = {ofs_i[OFS_W-1:2], 2'b00};

  always_comb begin
    unique case (size_i)
      2'd0:    be = 4'b0001 << ofs_i[1:0];
      2'd1:    be = 4'b0011 << ofs_i[1:0];
      default: be = 4'hF;
    endcase
  end

  assign dw0_o  = {fmt_type, 24'h000001};
  assign dw1_o  = {root_bus_i, ROOT_DEVFN, (write_i ? WR_TAG : RD_TAG), 4'h0, be};
  assign dw2_o  = {bus_i, devfn_i, {PAD_W{1'b0}}, ofs_dw};
  assign data_o = write_i ? (wdata_i << {ofs_i[1:0], 3'b000}) : '0;
  // reads always use the two-beat form
  assign three_beat_o = write_i && (ofs_i[2:0] == 3'b000);
  assign prim_hit_o   = write_i && local_bus && (ofs_dw == PRIM_OFS);
endmodule

// File: rtl/cfg_beat_seq.sv
module cfg_beat_seq
  import cfg_tlp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [DW-1:0] dw0_i,
  input  logic [DW-1:0] dw1_i,
  input  logic [DW-1:0] dw2_i,
  input  logic [DW-1:0] data_i,
  input  logic          three_beat_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [2*DW-1:0] tx_data_o,
  output logic          tx_sop_o,
  output logic          tx_eop_o,
  input  logic          cpl_valid_i,
  output logic          done_o,
  output logic          busy_o
);
  seq_state_e state_q, state_d;
  logic [DW-1:0] dw0_q, dw1_q, dw2_q, data_q;
  logic three_q;
  logic start, fire;

  assign req_ready_o = (state_q == ST_IDLE);
  assign start       = req_valid_i && req_ready_o;
  assign tx_valid_o  = (state_q == ST_BEAT1) || (state_q == ST_BEAT2) || (state_q == ST_BEAT3);
  assign fire        = tx_valid_o && tx_ready_i;
  assign busy_o      = !req_ready_o;
  assign done_o      = (state_q == ST_WAIT) && cpl_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_BEAT1;
      ST_BEAT1: if (fire) state_d = ST_BEAT2;
      ST_BEAT2: if (fire) state_d = three_q ? ST_BEAT3 : ST_WAIT;
      ST_BEAT3: if (fire) state_d = ST_WAIT;
      ST_WAIT:  if (cpl_valid_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tx_data_o = '0;
    tx_sop_o  = 1'b0;
    tx_eop_o  = 1'b0;
    unique case (state_q)
      ST_BEAT1: begin
        tx_data_o = {dw1_q, dw0_q};
        tx_sop_o  = 1'b1;
      end
      ST_BEAT2: begin
        tx_data_o = three_q ? {{DW{1'b0}}, dw2_q} : {data_q, dw2_q};
        tx_eop_o  = !three_q;
      end
      ST_BEAT3: begin
        tx_data_o = {{DW{1'b0}}, data_q};
        tx_eop_o  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dw0_q   <= '0;
      dw1_q   <= '0;
      dw2_q   <= '0;
      data_q  <= '0;
      three_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) begin
        dw0_q   <= dw0_i;
        dw1_q   <= dw1_i;
        dw2_q   <= dw2_i;
        data_q  <= data_i;
        three_q <= three_beat_i;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_eop_o));
  assert_sop_eop_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_sop_o && tx_eop_o));
  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> busy_o && tx_valid_o && tx_sop_o);
  assert_eop_wait_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_eop_o |=> busy_o && !tx_valid_o);
endmodule

// File: rtl/cfg_root_bus_reg.sv
module cfg_root_bus_reg #(
  parameter logic [7:0] RESET_ROOT_BUS = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] val_i,
  output logic [7:0] root_bus_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     root_bus_o <= RESET_ROOT_BUS;
    else if (load_i) root_bus_o <= val_i;
  end
endmodule

// File: rtl/cfg_tlp_builder.sv
module cfg_tlp_builder
  import cfg_tlp_pkg::*;
#(
  parameter int unsigned OFS_W = 12,
  parameter logic [7:0] ROOT_DEVFN = 8'h00,
  parameter logic [7:0] RESET_ROOT_BUS = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [7:0]       req_bus_i,
  input  logic [7:0]       req_devfn_i,
  input  logic [OFS_W-1:0] req_offset_i,
  input  logic [1:0]       req_size_i,
  input  logic [31:0]      req_wdata_i,
  output logic             tx_valid_o,
  input  logic             tx_ready_i,
  output logic [63:0]      tx_data_o,
  output logic             tx_sop_o,
  output logic             tx_eop_o,
  input  logic             cpl_valid_i,
  input  logic             cpl_ok_i,
  output logic             busy_o,
  output logic [7:0]       root_bus_o
);
  logic [DW-1:0] dw0, dw1, dw2, data;
  logic three_beat, prim_hit, done;
  logic upd_pend_q;
  logic [7:0] upd_val_q;

  cfg_hdr_gen #(
    .OFS_W(OFS_W), .ROOT_DEVFN(ROOT_DEVFN)
  ) u_hdr (
    .write_i(req_write_i), .bus_i(req_bus_i), .devfn_i(req_devfn_i),
    .ofs_i(req_offset_i), .size_i(req_size_i), .wdata_i(req_wdata_i),
    .root_bus_i(root_bus_o), .dw0_o(dw0), .dw1_o(dw1), .dw2_o(dw2),
    .data_o(data), .three_beat_o(three_beat), .prim_hit_o(prim_hit)
  );

  cfg_beat_seq u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o,
    .dw0_i(dw0), .dw1_i(dw1), .dw2_i(dw2), .data_i(data),
    .three_beat_i(three_beat), .tx_valid_o, .tx_ready_i, .tx_data_o,
    .tx_sop_o, .tx_eop_o, .cpl_valid_i, .done_o(done), .busy_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_pend_q <= 1'b0;
      upd_val_q  <= '0;
    end else if (req_valid_i && req_ready_o) begin
      upd_pend_q <= prim_hit;
      upd_val_q  <= data[7:0];
    end
  end

  cfg_root_bus_reg #(.RESET_ROOT_BUS(RESET_ROOT_BUS)) u_root (
    .clk_i, .rst_ni, .load_i(done && cpl_ok_i && upd_pend_q),
    .val_i(upd_val_q), .root_bus_o
  );

  assert_root_change_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(root_bus_o) |-> $past(cpl_valid_i && cpl_ok_i && busy_o && !tx_valid_o));
  assert_be_byte_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_size_i == 2'd0 |-> $countones(dw1[3:0]) == 1);
  assert_be_dword_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_size_i[1] |-> dw1[3:0] == 4'hF);
endmodule

// File: tb/sim_cfg_tlp_builder.sv
`timescale 1ns/1ps
module sim_cfg_tlp_builder;
  typedef struct {
    logic [63:0] d;
    logic sop;
    logic eop;
    string tag;
  } beat_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, tx_ready = 1, cpl_valid = 0, cpl_ok = 0;
  logic [7:0] req_bus = 0, req_devfn = 0;
  logic [11:0] req_ofs = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, tx_valid, tx_sop, tx_eop, busy;
  logic [63:0] tx_data;
  logic [7:0] root_bus;

  int errors = 0, checks = 0;
  int stall_mode = 0;
  logic [7:0] exp_root = 8'h00;
  beat_t q[$];

  always #2.5 clk = ~clk;

  cfg_tlp_builder u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_bus_i(req_bus), .req_devfn_i(req_devfn),
    .req_offset_i(req_ofs), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_sop_o(tx_sop), .tx_eop_o(tx_eop), .cpl_valid_i(cpl_valid), .cpl_ok_i(cpl_ok),
    .busy_o(busy), .root_bus_o(root_bus)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // backpressure pattern, changed just after each rising edge
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      tx_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end
  end

  // monitor / scoreboard
  initial begin
    logic held_v = 0;
    logic [63:0] held_d = 0;
    forever begin
      @(negedge clk);
      if (held_v) begin
        check(tx_valid && tx_data == held_d, "R9 hold", tx_data, held_d);
        held_v = 0;
      end
      if (tx_valid && !tx_ready) begin
        held_v = 1;
        held_d = tx_data;
      end
      if (tx_valid && tx_ready) begin
        if (q.size() == 0) begin
          check(0, "R10 unexpected beat", tx_data, 64'h0);
        end else begin
          beat_t e;
          e = q.pop_front();
          check(tx_data == e.d && tx_sop == e.sop && tx_eop == e.eop, e.tag,
                {tx_data[63:2], tx_sop, tx_eop}, {e.d[63:2], e.sop, e.eop});
        end
      end
    end
  end

  task automatic push(input logic [63:0] d, input logic s, input logic e, input string t);
    beat_t b;
    b.d = d; b.sop = s; b.eop = e; b.tag = t;
    q.push_back(b);
  endtask

  task automatic do_req(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [11:0] ofs, input logic [1:0] size,
                        input logic [31:0] wdata, input logic ok, input bit poke_busy);
    logic [7:0] ft;
    logic [3:0] be;
    logic [31:0] d0, d1, d2, dat;
    ft = (bus == exp_root) ? 8'h04 : 8'h05;
    if (wr) ft = ft | 8'h40;
    case (size)
      2'd0: be = 4'(4'b0001 << ofs[1:0]);
      2'd1: be = 4'(4'b0011 << ofs[1:0]);
      default: be = 4'hF;
    endcase
    dat = wr ? 32'(wdata << (8 * ofs[1:0])) : 32'h0;
    d0 = {ft, 24'h000001};
    d1 = {exp_root, 8'h00, (wr ? 8'h10 : 8'h1D), 4'h0, be};
    d2 = {bus, devfn, 4'h0, ofs[11:2], 2'b00};
    push({d1, d0}, 1, 0, "R1 R2 R4 R6 beat1");
    if (wr && ofs[2:0] == 3'b000) begin
      push({32'h0, d2}, 0, 0, "R3 R7 beat2");
      push({32'h0, dat}, 0, 1, "R5 R7 beat3");
    end else begin
      push({dat, d2}, 0, 1, "R3 R5 R8 beat2");
    end
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_bus = bus; req_devfn = devfn;
    req_ofs = ofs; req_size = size; req_wdata = wdata;
    @(posedge clk); #1;
    req_valid = 0;
    check(busy == 1 && req_ready == 0, "R10 busy after accept", {62'h0, busy, req_ready}, 64'h2);
    while (q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
    if (poke_busy) begin
      req_valid = 1; req_write = 0; req_bus = 8'h77; req_ofs = 12'h004;
      @(posedge clk); #1;
      req_valid = 0;
    end
    check(busy == 1, "R10 busy until completion", {63'h0, busy}, 64'h1);
    cpl_valid = 1; cpl_ok = ok;
    @(posedge clk); #1;
    cpl_valid = 0; cpl_ok = 0;
    if (wr && ok && bus == exp_root && {ofs[11:2], 2'b00} == 12'h018) exp_root = dat[7:0];
    check(busy == 0 && req_ready == 1, "R10 idle after completion", {62'h0, busy, req_ready}, 64'h1);
    check(root_bus == exp_root, "R11 R12 root bus", {56'h0, root_bus}, {56'h0, exp_root});
    repeat (3) @(posedge clk);
    check(q.size() == 0 && !tx_valid, "R10 no extra beat", {63'h0, tx_valid}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(busy == 0 && req_ready == 1 && tx_valid == 0 && root_bus == 8'h00,
          "R10 R11 reset state", {55'h0, busy, req_ready, tx_valid, root_bus}, {55'h0, 3'b010, 8'h00});
    rst_n = 1;
    // R1 R8: Type 0 read on root bus, dword
    do_req(0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 1, 0);
    // R1: Type 1 read, byte at offset 3
    do_req(0, 8'h01, 8'h08, 12'h103, 2'd0, 32'h0, 1, 0);
    // R7: aligned dword write, Type 1
    do_req(1, 8'h02, 8'h10, 12'h010, 2'd2, 32'hCAFEF00D, 1, 0);
    // R8 R5: unaligned halfword write at offset 2
    do_req(1, 8'h00, 8'h00, 12'h006, 2'd1, 32'h0000BEEF, 1, 0);
    // R4: halfword at offset[1:0]=3 truncated enables
    do_req(1, 8'h03, 8'h21, 12'hFFF, 2'd1, 32'h00001234, 1, 0);
    // R9: backpressure with busy pokes
    stall_mode = 1;
    do_req(1, 8'h04, 8'h00, 12'h208, 2'd0, 32'h000000A5, 1, 1);
    do_req(0, 8'h00, 8'h00, 12'h00C, 2'd2, 32'h0, 1, 1);
    stall_mode = 0;
    // R12: near misses
    do_req(1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h00000009, 0, 0);
    do_req(0, 8'h00, 8'h00, 12'h018, 2'd2, 32'h0, 1, 0);
    do_req(1, 8'h06, 8'h00, 12'h018, 2'd2, 32'h00000009, 1, 0);
    // R11: update root bus to 5
    do_req(1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h00010005, 1, 0);
    // R1 R2: bus 5 now Type 0, bus 0 now Type 1, requester id carries 5
    do_req(0, 8'h05, 8'h00, 12'h000, 2'd2, 32'h0, 1, 0);
    do_req(1, 8'h00, 8'h00, 12'h004, 2'd2, 32'h11223344, 1, 0);
    // R11: byte write to 0x19 on root moves shifted data lane 0 (zero)
    do_req(1, 8'h05, 8'h00, 12'h019, 2'd0, 32'h00000007, 1, 0);
    do_req(0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule